// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block collects interrupt requests from five peripheral sources and chooses which one the processor services next. Each source has one bit in a request register and one bit in a mask register. A single global arm bit gates the whole controller. Peripherals raise a request with a one-cycle pulse, and the bit stays latched until it is serviced or rewritten. The processor reads and writes both registers through a simple byte-wide register port.

When the global arm bit is set and at least one source is both requested and unmasked, the controller raises its pending output. It also presents the handler address of the most urgent such source. The vertical-blank source (bit 0) is the most urgent and the keypad source (bit 4) the least. The addresses start at 0x0040 and step by 8 bytes per bit. When the processor acknowledges, the controller clears that one request bit and drops the global arm bit. While that handler runs, nothing else can interrupt it unless software arms the controller again. Two separate inputs arm and disarm the controller, for the instructions that do so.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, all request bits, mask bits and the global arm bit are 0, so pending is low. Reading 0xFF0F returns 0xE0 and reading 0xFFFF returns 0x00.
- R2: A one-cycle pulse on `src_req[i]` sets request bit i on the next clock. The bit stays set on later cycles with no further pulse.
- R3: `irq_pending` is high exactly when the arm bit is set and the AND of the request and mask registers is nonzero.
- R4: The selected source is the lowest-numbered bit of (request AND mask). `irq_vector` is 0x0040 + 8 × that bit number, so bits 0..4 give 0x0040, 0x0048, 0x0050, 0x0058 and 0x0060.
- R5: `irq_ack` while pending clears only the selected request bit and the arm bit. All other request bits keep their values.
- R6: `arm_set` sets the arm bit and `arm_clr` clears it. When either `arm_clr` or a taken acknowledge occurs in the same cycle as `arm_set`, the arm bit ends up 0.
- R7: A write to the request register at 0xFF0F loads bits 4:0. Any `src_req` bit pulsed in the same cycle ends up set.
- R8: Reads of 0xFF0F return 1 in bits 7:5 and the request bits in bits 4:0.
- R9: The mask register is at 0xFFFF. Writes load bits 4:0, and reads return the mask in bits 4:0 with 0 in bits 7:5.
- R10: Setting the arm bit after an acknowledge makes a still-latched lower-priority source pending, with its own vector.
- R11: `irq_ack` while not pending has no effect on the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_req | input | 5 | Request pulses; bit 0 vertical blank, 1 display status, 2 timer, 3 serial, 4 keypad |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| arm_set | input | 1 | Sets the global arm bit |
| arm_clr | input | 1 | Clears the global arm bit |
| irq_ack | input | 1 | Processor accepts the presented interrupt |
| irq_pending | output | 1 | An armed, unmasked request exists |
| irq_vector | output | 16 | Handler address of the selected source |

## Verification
The arbitration is driven from a table of request and mask patterns. These include single sources at each of the five positions, all sources together, and patterns where the request and mask overlap in only one bit. Together they show that the choice follows the AND of the two registers and not either one alone, and that the lowest bit wins. Cases where the arm bit is clear, or where request and mask do not overlap, separate the gating condition from the selection itself. Directed sequences then cover several cases. One is an acknowledge with two sources latched, followed by re-arming, which shows nesting. Others are a request that collides with a register write, and simultaneous arm and disarm. The last is an acknowledge while nothing is pending.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_SRC_N   = 5;
  localparam int unsigned IRQ_ADDR_W  = 16;
  localparam int unsigned IRQ_DATA_W  = 8;

  typedef enum logic [2:0] {
    SRC_VBLANK = 3'd0,
    SRC_DISP   = 3'd1,
    SRC_TIMER  = 3'd2,
    SRC_SERIAL = 3'd3,
    SRC_KEYPAD = 3'd4
  } irq_src_e;
endpackage

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_val,
  input  logic         clr_en,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] set_req,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_q, flags_d;
  logic         upd_en;

  always_comb begin
    flags_d = flags_q;
    if (wr_en)  flags_d = wr_val;
    if (clr_en) flags_d = flags_d & ~clr_mask;
    flags_d = flags_d | set_req;
  end

  assign upd_en = wr_en | clr_en | (|set_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (upd_en) flags_q <= flags_d;
  end

  assign flags = flags_q;

  // R7
  req_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_req) |=> ((flags_q & $past(set_req)) == $past(set_req)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr_en && set_req == '0) |=> $stable(flags_q));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_val,
  output logic [N-1:0] mask
);
  logic [N-1:0] mask_q, mask_d;

  always_comb mask_d = wr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= mask_d;
  end

  assign mask = mask_q;

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/irq_master_en.sv
module irq_master_en (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic take_i,
  output logic armed
);
  logic arm_q, arm_d, arm_ce;

  assign arm_ce = set_i | clr_i | take_i;

  always_comb begin
    arm_d = arm_q;
    if (set_i)          arm_d = 1'b1;
    if (clr_i | take_i) arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arm_q <= 1'b0;
    else if (arm_ce) arm_q <= arm_d;
  end

  assign armed = arm_q;

  // R6
  disarm_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i || take_i) |=> !arm_q);
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int unsigned N        = 5,
  parameter int unsigned ADDR_W   = 16,
  parameter logic [15:0] VEC_BASE = 16'h0040,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      active,
  output logic              any,
  output logic [N-1:0]      grant,
  output logic [ADDR_W-1:0] vector
);
  localparam logic [ADDR_W-1:0] VEC_TOP = ADDR_W'(VEC_BASE) + ADDR_W'((N-1)*VEC_STEP);

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_grant
      if (gi == 0) begin : g_first
        assign grant[gi] = active[gi];
      end else begin : g_rest
        assign grant[gi] = active[gi] & ~(|active[gi-1:0]);
      end
    end
  endgenerate

  assign any = |active;

  always_comb begin
    vector = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) vector = vector | (ADDR_W'(VEC_BASE) + ADDR_W'(i * VEC_STEP));
    end
  end

  // R4
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (vector >= ADDR_W'(VEC_BASE) && vector <= VEC_TOP));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned N         = IRQ_SRC_N,
  parameter int unsigned ADDR_W    = IRQ_ADDR_W,
  parameter int unsigned DATA_W    = IRQ_DATA_W,
  parameter logic [15:0] FLAG_ADDR = 16'hFF0F,
  parameter logic [15:0] MASK_ADDR = 16'hFFFF,
  parameter logic [15:0] VEC_BASE  = 16'h0040,
  parameter int unsigned VEC_STEP  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      src_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              arm_set,
  input  logic              arm_clr,
  input  logic              irq_ack,
  output logic              irq_pending,
  output logic [ADDR_W-1:0] irq_vector
);
  localparam int unsigned PAD_W = DATA_W - N;

  logic [1:0]   rst_sync_q;
  logic         rst_int_n;
  logic [N-1:0] flags, mask, active, grant;
  logic         armed, any, take;
  logic         hit_flag, hit_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign hit_flag = (bus_addr == ADDR_W'(FLAG_ADDR));
  assign hit_mask = (bus_addr == ADDR_W'(MASK_ADDR));
  assign take     = irq_ack & irq_pending;

  irq_flag_reg #(.N(N)) u_flag (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(bus_wr & hit_flag), .wr_val(bus_wdata[N-1:0]),
    .clr_en(take), .clr_mask(grant),
    .set_req(src_req), .flags(flags)
  );

  irq_mask_reg #(.N(N)) u_mask (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(bus_wr & hit_mask), .wr_val(bus_wdata[N-1:0]),
    .mask(mask)
  );

  irq_master_en u_arm (
    .clk(clk), .rst_n(rst_int_n),
    .set_i(arm_set), .clr_i(arm_clr), .take_i(take),
    .armed(armed)
  );

  assign active = flags & mask;

  irq_prio_sel #(.N(N), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_sel (
    .clk(clk), .rst_n(rst_int_n),
    .active(active), .any(any), .grant(grant), .vector(irq_vector)
  );

  assign irq_pending = armed & any;

  always_comb begin
    bus_rdata = '0;
    if (hit_flag)      bus_rdata = {{PAD_W{1'b1}}, flags};
    else if (hit_mask) bus_rdata = {{PAD_W{1'b0}}, mask};
  end

  // R5
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_ack && irq_pending) |=> !irq_pending);

  // R6
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    arm_clr |=> !irq_pending);
endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
  localparam logic [15:0] FA = 16'hFF0F;
  localparam logic [15:0] MA = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  src_req = '0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        arm_set = 1'b0, arm_clr = 1'b0, irq_ack = 1'b0;
  logic        irq_pending;
  logic [15:0] irq_vector;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .arm_set(arm_set), .arm_clr(arm_clr), .irq_ack(irq_ack),
    .irq_pending(irq_pending), .irq_vector(irq_vector)
  );

  // entry: [14:10] request, [9:5] mask, [4] arm, [3] expected pending, [2:0] expected source
  localparam logic [14:0] TBL [12] = '{
    {5'b00001, 5'b00001, 1'b1, 1'b1, 3'd0},
    {5'b11111, 5'b11111, 1'b1, 1'b1, 3'd0},
    {5'b11110, 5'b11111, 1'b1, 1'b1, 3'd1},
    {5'b10100, 5'b10100, 1'b1, 1'b1, 3'd2},
    {5'b11000, 5'b11111, 1'b1, 1'b1, 3'd3},
    {5'b10000, 5'b10000, 1'b1, 1'b1, 3'd4},
    {5'b11111, 5'b00000, 1'b1, 1'b0, 3'd0},
    {5'b00000, 5'b11111, 1'b1, 1'b0, 3'd0},
    {5'b11111, 5'b11111, 1'b0, 1'b0, 3'd0},
    {5'b01010, 5'b10101, 1'b1, 1'b0, 3'd0},
    {5'b01110, 5'b01011, 1'b1, 1'b1, 3'd1},
    {5'b10101, 5'b01100, 1'b1, 1'b1, 3'd2}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic pulse_arm(input logic s, input logic c, input logic a);
    arm_set = s; arm_clr = c; irq_ack = a;
    step();
    arm_set = 1'b0; arm_clr = 1'b0; irq_ack = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    chk("R1 pending", 16'(irq_pending), 16'h0);
    rd(FA, d); chk("R1 flag read", 16'(d), 16'h00E0);
    rd(MA, d); chk("R1 mask read", 16'(d), 16'h0000);

    // R3 R4 R8 table walk
    for (int k = 0; k < 12; k++) begin
      pulse_arm(1'b0, 1'b1, 1'b0);
      wr(MA, {3'b000, TBL[k][9:5]});
      wr(FA, {3'b000, TBL[k][14:10]});
      if (TBL[k][4]) pulse_arm(1'b1, 1'b0, 1'b0);
      chk("R3 pending", 16'(irq_pending), 16'(TBL[k][3]));
      if (TBL[k][3]) chk("R4 vector", irq_vector, 16'h0040 + 16'(TBL[k][2:0]) * 16'd8);
      rd(FA, d); chk("R8 flag read", 16'(d), {8'h00, 3'b111, TBL[k][14:10]});
    end

    // R9 mask register
    wr(MA, 8'hFF);
    rd(MA, d); chk("R9 mask read", 16'(d), 16'h001F);

    // R2 pulse latches and persists
    pulse_arm(1'b0, 1'b1, 1'b0);
    wr(FA, 8'h00);
    src_req = 5'b00100; step(); src_req = '0;
    rd(FA, d); chk("R2 set", 16'(d), 16'h00E4);
    repeat (4) step();
    rd(FA, d); chk("R2 hold", 16'(d), 16'h00E4);

    // R5 / R10 acknowledge and nesting
    wr(FA, 8'h05);
    pulse_arm(1'b1, 1'b0, 1'b0);
    chk("R5 pre vector", irq_vector, 16'h0040);
    pulse_arm(1'b0, 1'b0, 1'b1);
    rd(FA, d); chk("R5 only selected cleared", 16'(d), 16'h00E4);
    chk("R5 pending dropped", 16'(irq_pending), 16'h0);
    pulse_arm(1'b1, 1'b0, 1'b0);
    chk("R10 nested pending", 16'(irq_pending), 16'h1);
    chk("R10 nested vector", irq_vector, 16'h0050);

    // R11 ack while not pending
    pulse_arm(1'b0, 1'b1, 1'b0);
    wr(FA, 8'h03);
    pulse_arm(1'b0, 1'b0, 1'b1);
    rd(FA, d); chk("R11 flags kept", 16'(d), 16'h00E3);

    // R7 request beats write
    bus_addr = FA; bus_wdata = 8'h00; bus_wr = 1'b1; src_req = 5'b00010;
    step();
    bus_wr = 1'b0; src_req = '0;
    rd(FA, d); chk("R7 collision", 16'(d), 16'h00E2);

    // R6 disarm beats arm; ack beats arm
    pulse_arm(1'b1, 1'b1, 1'b0);
    chk("R6 clr over set", 16'(irq_pending), 16'h0);
    pulse_arm(1'b1, 1'b0, 1'b0);
    chk("R6 set", 16'(irq_pending), 16'h1);
    pulse_arm(1'b1, 1'b0, 1'b1);
    chk("R6 ack over set", 16'(irq_pending), 16'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule